// File: doc/BRIEF.md
# Sampled Window Readout Aligner

The aligner turns an event directory word into a fixed-length stream of samples read from a circular sample memory. A word whose trigger bit is set carries a next-sample address. The two lowest bits of that address are a status code. The code says how far the recorded start is off. It also says whether samples next to the stop point were lost or whether an extra sample beyond the stop was kept. The block corrects the start address and walks the memory through a synchronous read port with a latency of one cycle. It delivers exactly `WIN_LEN` slots on a valid/ready output.

Slots for samples that were never stored come out flagged as missing, with zero data. The extra sample beyond the stop is still read. It is shown as a single-cycle post-stop pulse and is not counted as a slot. All address arithmetic wraps modulo the memory depth, `2**ADDR_W`. While a window is being read out, the directory input is held off.

Top module: `window_aligner`

## Requirements
- R1: A directory word accepted while its trigger bit (bit `TRIG_BIT`, default 31) is 0 is discarded. No memory read, output slot or post-stop pulse follows, and `dir_ready` stays 1.
- R2: Code `dir_word[1:0]` = 2'b00: the window is `WIN_LEN` valid samples read from consecutive addresses starting at the address field `A` = `dir_word[ADDR_W-1:0]`, with no missing flag.
- R3: Code `dir_word[1:0]` = 2'b10 (bit0 = 0, bit1 = 1): reading starts at `A+1`. The first `WIN_LEN-1` slots are samples and the last slot is flagged missing.
- R4: Code `dir_word[1:0]` = 2'b01 (bit0 = 1, bit1 = 0): reading starts at `A+2`. The first `WIN_LEN-2` slots are samples and the last two slots are flagged missing.
- R5: Code `dir_word[1:0]` = 2'b11: the sample at `A-1` is read first. It appears only as a one-cycle `out_post_stop` pulse, with `out_valid` low in that cycle. The `WIN_LEN` slots that follow are the samples from `A` onward.
- R6: Every read address is taken modulo `2**ADDR_W`, so windows that cross the top address wrap to address 0. Bits of the directory word between `ADDR_W` and the trigger bit have no effect.
- R7: A slot flagged missing has `out_data` equal to 0.
- R8: Each window has exactly `WIN_LEN` accepted slots, and `out_last` is set on the final one only.
- R9: While `out_valid` is 1 and `out_ready` is 0, the slot (data, missing, last) is held unchanged and no memory read is issued.
- R10: `dir_ready` is 0 from the cycle after a triggered word is accepted until the cycle after the window's last slot is accepted.
- R11: After reset, `dir_ready` is 1 and `out_valid`, `out_post_stop` and `ram_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_word | input | DIR_W | Event directory word |
| dir_valid | input | 1 | Directory word present |
| dir_ready | output | 1 | Aligner can take a directory word |
| ram_en | output | 1 | Sample memory read enable |
| ram_addr | output | ADDR_W | Sample memory read address |
| ram_rdata | input | DATA_W | Read data, one cycle after `ram_en`, held while `ram_en` is low |
| out_ready | input | 1 | Downstream accepts a slot |
| out_data | output | DATA_W | Slot sample value |
| out_valid | output | 1 | Slot present |
| out_missing | output | 1 | Slot stands for a sample that was never stored |
| out_last | output | 1 | Final slot of the window |
| out_post_stop | output | 1 | Pulse for the dropped sample taken beyond the stop |

## Verification
The bench covers all four status codes at addresses where the corrected window runs past the top of memory. A design without proper modulo wrap would fetch samples from beyond memory instead of from address 0. The bench holds `out_ready` low at random times in the middle of windows. A design that issues reads during a stall would lose or repeat samples. Each window is checked slot by slot against a model. An off-by-one in the correction shows up as every sample being shifted by one address. Wrong counting of missing slots shows up as an early or late `out_last`. The bench also offers words with the trigger bit clear and words with junk in their upper address bits, and checks that neither produces output.

// File: rtl/wa_pkg.sv
// Package: shared types for the window aligner.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package wa_pkg;

    // Kind of one slot in the readout sequence
    typedef enum logic [1:0] {
        SLOT_READ = 2'd0,   // real sample read from memory
        SLOT_MISS = 2'd1,   // sample never stored, no read
        SLOT_POST = 2'd2    // sample beyond the stop, read then dropped
    } slot_kind_t;

    // Window shape implied by the status code
    typedef struct packed {
        logic       post;   // one extra leading read beyond the stop
        logic [1:0] nmiss;  // count of trailing missing slots
    } win_fix_t;

endpackage

// File: rtl/wa_dir_decode.sv
// Module: wa_dir_decode
// Splits a directory word into trigger flag, corrected start address and
// window shape. Purely combinational.
// Assumes the status code sits in the two lowest address bits, ADDR_W >= 2.
module wa_dir_decode
    import wa_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              trig_bit,
    input  logic [ADDR_W-1:0] addr_field,
    output logic              trig,
    output logic [ADDR_W-1:0] start_addr,
    output win_fix_t          fix
);

    logic [ADDR_W-1:0] offset;

    // Map the status code to an address offset and a window shape
    always_comb begin
        offset    = '0;
        fix.post  = 1'b0;
        fix.nmiss = 2'd0;
        unique case (addr_field[1:0])
            2'b00: offset = '0;
            2'b10: begin
                offset    = ADDR_W'(1);
                fix.nmiss = 2'd1;
            end
            2'b01: begin
                offset    = ADDR_W'(2);
                fix.nmiss = 2'd2;
            end
            default: begin
                offset   = '1;          // minus one, modulo depth
                fix.post = 1'b1;
            end
        endcase
    end

    // Corrected start, wrapping naturally at ADDR_W bits
    assign start_addr = addr_field + offset;
    assign trig       = trig_bit;

endmodule

// File: rtl/wa_slot_seq.sv
// Module: wa_slot_seq
// Walks one window slot by slot and issues memory reads for slots that
// need data. One slot is produced per cycle in which adv is high.
// Assumes load only arrives while the sequencer is idle.
module wa_slot_seq
    import wa_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int WIN_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_start,
    input  win_fix_t          load_fix,
    input  logic              adv,
    output logic              active,
    output logic              emit,
    output slot_kind_t        emit_kind,
    output logic              emit_last,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int CNT_W = $clog2(WIN_LEN + 2);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q;
    win_fix_t          fix_q;
    logic [CNT_W-1:0]  total;
    logic [CNT_W-1:0]  real_idx;
    logic [CNT_W-1:0]  read_lim;

    // Classify the current slot from its index and the window shape
    always_comb begin
        total     = CNT_W'(WIN_LEN) + CNT_W'(fix_q.post);
        real_idx  = idx_q - CNT_W'(fix_q.post);
        read_lim  = CNT_W'(WIN_LEN) - CNT_W'(fix_q.nmiss);
        if (fix_q.post && idx_q == '0) begin
            emit_kind = SLOT_POST;
        end else if (real_idx < read_lim) begin
            emit_kind = SLOT_READ;
        end else begin
            emit_kind = SLOT_MISS;
        end
        emit_last = (idx_q == total - CNT_W'(1));
    end

    assign emit    = active && adv;
    assign rd_en   = emit && (emit_kind != SLOT_MISS);
    assign rd_addr = addr_q;

    // Load a new window or step to the next slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            addr_q <= '0;
            idx_q  <= '0;
            fix_q  <= '0;
        end else if (load) begin
            active <= 1'b1;
            addr_q <= load_start;
            idx_q  <= '0;
            fix_q  <= load_fix;
        end else if (emit) begin
            if (emit_kind != SLOT_MISS) begin
                addr_q <= addr_q + ADDR_W'(1);
            end
            idx_q <= idx_q + CNT_W'(1);
            if (emit_last) begin
                active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wa_out_stage.sv
// Module: wa_out_stage
// Holds the slot whose memory data is on ram_rdata and presents it with
// valid/ready. Post-stop slots leave after one cycle without a handshake.
// Assumes the memory keeps its read data while its enable is low.
module wa_out_stage
    import wa_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_emit,
    input  slot_kind_t        in_kind,
    input  logic              in_last,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              out_ready,
    output logic              adv,
    output logic              full,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_missing,
    output logic              out_last,
    output logic              out_post_stop
);

    slot_kind_t kind_q;
    logic       last_q;

    // Stage may take a new slot when empty, draining or holding a post pulse
    assign adv = !full || (kind_q == SLOT_POST) || out_ready;

    // Capture the slot issued by the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            kind_q <= SLOT_READ;
            last_q <= 1'b0;
        end else if (adv) begin
            full   <= in_emit;
            kind_q <= in_kind;
            last_q <= in_last;
        end
    end

    // Drive the slot fields; missing slots carry zero data
    always_comb begin
        out_valid     = full && (kind_q != SLOT_POST);
        out_post_stop = full && (kind_q == SLOT_POST);
        out_missing   = out_valid && (kind_q == SLOT_MISS);
        out_last      = out_valid && last_q;
        out_data      = (kind_q == SLOT_READ) ? ram_rdata : '0;
    end

endmodule

// File: rtl/window_aligner.sv
// Module: window_aligner (top)
// Accepts triggered directory words, corrects the start pointer from the
// embedded status code and streams a WIN_LEN slot window from memory.
// Assumes a power-of-two memory of 2**ADDR_W words with one-cycle
// synchronous read that holds its data while ram_en is low.
module window_aligner
    import wa_pkg::*;
#(
    parameter int DIR_W    = 32,
    parameter int TRIG_BIT = 31,
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 12,
    parameter int WIN_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIR_W-1:0]  dir_word,
    input  logic              dir_valid,
    output logic              dir_ready,
    output logic              ram_en,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_missing,
    output logic              out_last,
    output logic              out_post_stop
);

    logic              trig;
    logic [ADDR_W-1:0] start_addr;
    win_fix_t          fix;
    logic              load;
    logic              seq_active;
    logic              emit;
    slot_kind_t        emit_kind;
    logic              emit_last;
    logic              adv;
    logic              st_full;
    logic              unused_word;

    // Bits between the address field and the trigger bit carry no meaning
    assign unused_word = ^dir_word;

    wa_dir_decode #(.ADDR_W(ADDR_W)) u_dec (
        .trig_bit   (dir_word[TRIG_BIT]),
        .addr_field (dir_word[ADDR_W-1:0]),
        .trig       (trig),
        .start_addr (start_addr),
        .fix        (fix)
    );

    // Busy from window start until its last slot has left the stage
    assign dir_ready = !seq_active && !st_full;
    assign load      = dir_valid && dir_ready && trig;

    wa_slot_seq #(.ADDR_W(ADDR_W), .WIN_LEN(WIN_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_start (start_addr),
        .load_fix   (fix),
        .adv        (adv),
        .active     (seq_active),
        .emit       (emit),
        .emit_kind  (emit_kind),
        .emit_last  (emit_last),
        .rd_en      (ram_en),
        .rd_addr    (ram_addr)
    );

    wa_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_emit       (emit),
        .in_kind       (emit_kind),
        .in_last       (emit_last),
        .ram_rdata     (ram_rdata),
        .out_ready     (out_ready),
        .adv           (adv),
        .full          (st_full),
        .out_data      (out_data),
        .out_valid     (out_valid),
        .out_missing   (out_missing),
        .out_last      (out_last),
        .out_post_stop (out_post_stop)
    );

endmodule

// File: rtl/window_aligner_checker.sv
// Module: window_aligner_checker
// Protocol and framing properties of the window aligner, bound to the top.
module window_aligner_checker #(
    parameter int DATA_W  = 12,
    parameter int WIN_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_ready,
    input logic              ram_en,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_missing,
    input logic              out_last,
    input logic              out_post_stop
);

    localparam int CNT_W = $clog2(WIN_LEN + 1);
    logic [CNT_W-1:0] acc_cnt;

    // Count accepted slots within the current window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (out_valid && out_ready) begin
            acc_cnt <= out_last ? '0 : acc_cnt + CNT_W'(1);
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_missing) && $stable(out_last));

    assert_no_read_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> !(out_valid && !out_ready));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_missing |-> out_valid && (out_data == '0));

    assert_post_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_post_stop |-> !out_valid);

    assert_post_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_post_stop |=> !out_post_stop);

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_post_stop) |-> !dir_ready);

    assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> acc_cnt == CNT_W'(WIN_LEN - 1));

endmodule

bind window_aligner window_aligner_checker #(
    .DATA_W  (DATA_W),
    .WIN_LEN (WIN_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dir_ready     (dir_ready),
    .ram_en        (ram_en),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .out_missing   (out_missing),
    .out_last      (out_last),
    .out_post_stop (out_post_stop)
);

// File: tb/window_aligner_test.sv
module window_aligner_test;

    localparam int DIR_W   = 32;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 12;
    localparam int WIN_LEN = 16;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int LIMIT   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIR_W-1:0]  dir_word = '0;
    logic              dir_valid = 1'b0;
    logic              dir_ready;
    logic              ram_en;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rdata = '0;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              out_valid;
    logic              out_missing;
    logic              out_last;
    logic              out_post_stop;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ready_pct = 100;
    bit done = 1'b0;

    always #10 clk = ~clk;

    window_aligner uut (
        .clk(clk), .rst_n(rst_n), .dir_word(dir_word), .dir_valid(dir_valid),
        .dir_ready(dir_ready), .ram_en(ram_en), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .out_ready(out_ready), .out_data(out_data),
        .out_valid(out_valid), .out_missing(out_missing), .out_last(out_last),
        .out_post_stop(out_post_stop)
    );

    function automatic logic [DATA_W-1:0] mem_val(input int a);
        return DATA_W'(((a % DEPTH) * 37 + 11) % 4093 + 1);
    endfunction

    // Memory model: one-cycle read, data held while disabled
    always @(posedge clk) if (ram_en) ram_rdata <= mem_val(int'(ram_addr));

    // Downstream ready, changed just after each rising edge
    always @(posedge clk) begin
        #1 out_ready = (($urandom % 100) < ready_pct);
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, LIMIT);
            report();
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Run one triggered window and compare each slot with the model
    task automatic run_window(input logic [DIR_W-1:0] w, input string req);
        int a = int'(w[ADDR_W-1:0]);
        int c = int'(w[1:0]);
        int st = a, nm = 0, pexp = 0, got = 0, pcnt = 0, guard = 0;
        bit busy_ok = 1'b1, stall = 1'b0;
        logic [DATA_W+1:0] held = '0;
        case (c)
            2: begin st = a + 1; nm = 1; end
            1: begin st = a + 2; nm = 2; end
            3: begin st = a; pexp = 1; end
            default: st = a;
        endcase
        @(posedge clk); #2;
        dir_word = w; dir_valid = 1'b1;
        do @(negedge clk); while (!dir_ready);
        @(posedge clk); #2;
        dir_valid = 1'b0;
        while (got < WIN_LEN && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (dir_ready) busy_ok = 1'b0;
            if (stall) begin
                check(out_valid && {out_data, out_missing, out_last} == held,
                      "R9 hold", {out_data, out_missing, out_last}, held);
            end
            stall = out_valid && !out_ready;
            held  = {out_data, out_missing, out_last};
            if (out_post_stop) begin
                pcnt++;
                check(!out_valid, "R5 post alone", out_valid, 0);
            end
            if (out_valid && out_ready) begin
                logic [DATA_W-1:0] ed = (got < WIN_LEN - nm) ? mem_val(st + got) : '0;
                logic em = (got >= WIN_LEN - nm);
                logic el = (got == WIN_LEN - 1);
                check({out_data, out_missing, out_last} == {ed, em, el},
                      {req, " slot"}, {out_data, out_missing, out_last}, {ed, em, el});
                got++;
            end
        end
        check(got == WIN_LEN, "R8 slot count", got, WIN_LEN);
        check(pcnt == pexp, "R5 post count", pcnt, pexp);
        check(busy_ok, "R10 held off", busy_ok, 1);
        @(negedge clk);
        check(dir_ready, "R10 released", dir_ready, 1);
    endtask

    function automatic logic [DIR_W-1:0] mk(input int a, input int code, input int junk);
        logic [DIR_W-1:0] w = '0;
        w[31] = 1'b1;
        w[30:ADDR_W] = (30 - ADDR_W + 1)'(junk);
        w[ADDR_W-1:0] = ADDR_W'(a);
        w[1:0] = 2'(code);
        return w;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state, sampled while reset is still held
        @(negedge clk);
        check(dir_ready && !out_valid && !out_post_stop && !ram_en, "R11 reset",
              {dir_ready, out_valid, out_post_stop, ram_en}, 4'b1000);
        @(posedge clk); #2; rst_n = 1'b1;

        // R1 trigger clear: word consumed, nothing follows
        begin
            bit quiet = 1'b1;
            dir_word = 32'h0000_0104; dir_valid = 1'b1;
            @(posedge clk); #2; dir_valid = 1'b0;
            repeat (30) begin
                @(negedge clk);
                if (out_valid || out_post_stop || ram_en || !dir_ready) quiet = 1'b0;
            end
            check(quiet, "R1 untriggered ignored", quiet, 1);
        end

        // Directed codes, always ready
        run_window(mk(100, 0, 0), "R2 code00");
        run_window(mk(100, 2, 0), "R3 code10");
        run_window(mk(100, 1, 0), "R4 code01");
        run_window(mk(103, 3, 0), "R5 code11");
        // R6 wrap across the top address, with junk upper bits
        run_window(mk(DEPTH - 4, 0, 'h5a5a), "R6 wrap code00");
        run_window(mk(DEPTH - 2, 2, 'h1234), "R6 wrap code10");
        run_window(mk(DEPTH - 3, 1, 'h7fff), "R6 wrap code01");
        run_window(mk(DEPTH - 1, 3, 'h0f0f), "R6 wrap code11");
        run_window(mk(3, 3, 0), "R5 low code11");

        // Random windows with stalls (R9) and the missing-data rule (R7)
        ready_pct = 60;
        for (int i = 0; i < 40; i++) begin
            run_window(mk($urandom % DEPTH, $urandom % 4, $urandom), "R7 random");
        end
        ready_pct = 25;
        for (int i = 0; i < 10; i++) begin
            run_window(mk($urandom % DEPTH, $urandom % 4, $urandom), "R9 slow");
        end
        done = 1'b1;
        report();
    end

endmodule